// File: doc/BRIEF.md
# Elastic Lockstep Match Buffer

This block sits between two copies of a processor that execute the same program, each at its own pace. The leading (executive) copy marks each completed bus transfer with a strobe. On that strobe the block captures the 33-bit bus word, the address of the unit that sent it, and a flag that says the transfer carried no valid bus data. All of this goes into an eight-slot elastic queue. The trailing (standby) copy pops one slot on each of its own strobes. The block compares the popped word with the word on the standby bus. Only a word that differs and is not flagged as carrying no valid data counts as a mismatch.

The queue works like a rubber band. Nothing is ever dropped. When the executive side is a full queue ahead, the block raises a busy signal that stalls that side. When the queue is empty, a second busy signal holds the standby side. The first mismatch sets a sticky error flag. It also freezes the differing bit positions and the sender address of the failing word until software pulses a clear. A sixteen-deep history keeps the sender addresses of the most recent pops, and the error flag freezes it too. In updating mode the standby bus is fed from the queue head instead of from the standby's own units, and no comparison is made. All logic runs on one clock, and both sides' strobes are sampled at its rising edge.

Top module: `lockstep_match_buf`

## Requirements
- R1: After reset the queue is empty: `sb_busy`=1, `ex_busy`=0, `sb_drive_en`=0, `mism_flag`=0, `mism_bits`=0, `mism_sender`=0.
- R2: Words leave the queue in the order they were accepted, and each slot holds word, sender address and no-data flag together.
- R3: When eight entries are held, `ex_busy` is 1 from the cycle after the eighth accepted `ex_di`. An `ex_di` while `ex_busy` is high is ignored: no slot is added or overwritten.
- R4: `sb_busy` is 1 whenever the queue is empty. An `sb_di` while empty is ignored: no pop, no comparison, no history entry.
- R5: On an accepted pop outside updating mode, all 33 bits of the head word are compared with `sb_word`. On any difference, `mism_flag` goes to 1 one cycle later, `mism_bits` holds the XOR of the two words, and `mism_sender` holds the head's sender address.
- R6: A popped entry whose `ex_nodata` bit was 1 when it was pushed is never compared.
- R7: While `mism_flag` is 1, later mismatches do not change `mism_bits` or `mism_sender`. A one-cycle `mism_clr` pulse returns all three to 0 on the next cycle, and clear wins over a mismatch in the same cycle.
- R8: With `update_mode`=1 and the queue not empty, `sb_drive_en`=1 and `sb_drive_word` equals the head word. Pops in this mode never set `mism_flag`.
- R9: `rec_sender` for `rec_idx`=k gives the sender address of the k-th most recent accepted pop (0 = newest). Recording stops while `mism_flag` is 1, so the failing pop is the newest entry kept.
- R10: An `ex_di` and an `sb_di` accepted in the same cycle both take effect, and the fill level is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_di | input | 1 | Executive transfer strobe (push) |
| ex_word | input | WORD_W (33) | Executive bus word |
| ex_sender | input | SND_W (5) | Sender unit address of the executive transfer |
| ex_nodata | input | 1 | Transfer carries no valid bus data; skip its comparison |
| sb_di | input | 1 | Standby transfer strobe (pop) |
| sb_word | input | WORD_W (33) | Standby bus word to compare |
| update_mode | input | 1 | Standby is being loaded from the queue; no comparison |
| mism_clr | input | 1 | Pulse that clears the sticky mismatch record |
| rec_idx | input | $clog2(REC_DEPTH) (4) | Age index into the sender history |
| ex_busy | output | 1 | Simulated receiver-busy stall to the executive side |
| sb_busy | output | 1 | Simulated receiver-busy stall to the standby side |
| sb_drive_en | output | 1 | Enable for driving the queue head onto the standby bus |
| sb_drive_word | output | WORD_W (33) | Queue head word for the standby bus |
| mism_flag | output | 1 | Sticky mismatch flag |
| mism_bits | output | WORD_W (33) | Bit positions that differed in the first mismatch |
| mism_sender | output | SND_W (5) | Frozen sender address of the first mismatch |
| rec_sender | output | SND_W (5) | Sender address selected by `rec_idx` |

## Verification
A wrong read or write pointer shows up as a wrong `sb_drive_word` in updating mode on the very next cycle. It also shows up as a false `mism_flag` one cycle after the next pop. A wrong fill count shows as a busy output that is off by one strobe. An early or late `ex_busy` or `sb_busy` is visible right after the eighth push or the last pop. A broken freeze or history path is only visible after a second mismatch. It can be seen at `mism_bits` and at `rec_sender` with index 0, and the bench reads both right after that second pop.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int LSM_WORD_W_DEF = 33;
  localparam int LSM_DEPTH_DEF  = 8;
  localparam int LSM_SND_W_DEF  = 5;
  localparam int LSM_REC_DEF    = 16;

  // occupancy from two free-running strobe counters modulo span (span = 2*depth, power of two)
  function automatic int lsm_fill(int wr_cnt, int rd_cnt, int span);
    return (wr_cnt - rd_cnt) & (span - 1);
  endfunction

  // bit positions that disagree between the stored and the observed word
  function automatic logic [63:0] lsm_diff(logic [63:0] a, logic [63:0] b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/lsm_fifo.sv
module lsm_fifo #(
  parameter int WORD_W = 33,
  parameter int SND_W  = 5,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic [SND_W-1:0]  push_snd,
  input  logic              push_skip,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic [SND_W-1:0]  head_snd,
  output logic              head_skip,
  output logic [PW-1:0]     fill
);
  import lsm_pkg::*;
  localparam int EW = WORD_W + SND_W + 1;

  logic [PW-1:0] wr_cnt, rd_cnt;
  logic [EW-1:0] slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (push) wr_cnt <= wr_cnt + PW'(1);
      if (pop)  rd_cnt <= rd_cnt + PW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (push && wr_cnt[AW-1:0] == AW'(g))
        slot[g] <= {push_skip, push_snd, push_word};
    end
  end

  assign {head_skip, head_snd, head_word} = slot[rd_cnt[AW-1:0]];
  assign fill = PW'(lsm_fill(int'(wr_cnt), int'(rd_cnt), 2 * DEPTH));
endmodule

// File: rtl/lsm_compare.sv
module lsm_compare #(
  parameter int WORD_W = 33,
  parameter int SND_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              skip,
  input  logic [WORD_W-1:0] head_word,
  input  logic [SND_W-1:0]  head_snd,
  input  logic [WORD_W-1:0] sb_word,
  input  logic              clr,
  output logic              hit,
  output logic              flag,
  output logic [WORD_W-1:0] bits,
  output logic [SND_W-1:0]  snd
);
  import lsm_pkg::*;
  logic [WORD_W-1:0] diff;

  assign diff = WORD_W'(lsm_diff(64'(head_word), 64'(sb_word)));
  assign hit  = pop && !skip && (diff != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      bits <= '0;
      snd  <= '0;
    end else if (clr) begin
      flag <= 1'b0;
      bits <= '0;
      snd  <= '0;
    end else if (hit && !flag) begin
      flag <= 1'b1;
      bits <= diff;
      snd  <= head_snd;
    end
  end
endmodule

// File: rtl/lsm_recorder.sv
module lsm_recorder #(
  parameter int SND_W = 5,
  parameter int REC   = 16,
  localparam int RIW  = $clog2(REC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic [SND_W-1:0] rec_in,
  input  logic [RIW-1:0]   rd_idx,
  output logic [SND_W-1:0] rd_snd
);
  logic [SND_W-1:0] hist [REC];

  for (genvar g = 0; g < REC; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist[g] <= '0;
      else if (rec_en)
        hist[g] <= (g == 0) ? rec_in : hist[(g == 0) ? 0 : g - 1];
    end
  end

  assign rd_snd = hist[rd_idx];
endmodule

// File: rtl/lockstep_match_buf.sv
module lockstep_match_buf #(
  parameter int WORD_W    = lsm_pkg::LSM_WORD_W_DEF,
  parameter int SND_W     = lsm_pkg::LSM_SND_W_DEF,
  parameter int DEPTH     = lsm_pkg::LSM_DEPTH_DEF,
  parameter int REC_DEPTH = lsm_pkg::LSM_REC_DEF,
  localparam int FILL_W   = $clog2(DEPTH) + 1,
  localparam int RIW      = $clog2(REC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_di,
  input  logic [WORD_W-1:0] ex_word,
  input  logic [SND_W-1:0]  ex_sender,
  input  logic              ex_nodata,
  input  logic              sb_di,
  input  logic [WORD_W-1:0] sb_word,
  input  logic              update_mode,
  input  logic              mism_clr,
  input  logic [RIW-1:0]    rec_idx,
  output logic              ex_busy,
  output logic              sb_busy,
  output logic              sb_drive_en,
  output logic [WORD_W-1:0] sb_drive_word,
  output logic              mism_flag,
  output logic [WORD_W-1:0] mism_bits,
  output logic [SND_W-1:0]  mism_sender,
  output logic [SND_W-1:0]  rec_sender
);
  // named internal events, used by the bound checker
  logic              push_ok, pop_ok, cmp_hit;
  logic [FILL_W-1:0] fill;
  logic [WORD_W-1:0] head_word;
  logic [SND_W-1:0]  head_snd;
  logic              head_skip;

  assign ex_busy = (fill == FILL_W'(DEPTH));
  assign sb_busy = (fill == '0);
  assign push_ok = ex_di && !ex_busy;
  assign pop_ok  = sb_di && !sb_busy;

  lsm_fifo #(.WORD_W(WORD_W), .SND_W(SND_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_ok), .push_word(ex_word), .push_snd(ex_sender), .push_skip(ex_nodata),
    .pop(pop_ok), .head_word(head_word), .head_snd(head_snd), .head_skip(head_skip),
    .fill(fill)
  );

  lsm_compare #(.WORD_W(WORD_W), .SND_W(SND_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .pop(pop_ok), .skip(head_skip || update_mode),
    .head_word(head_word), .head_snd(head_snd), .sb_word(sb_word),
    .clr(mism_clr), .hit(cmp_hit),
    .flag(mism_flag), .bits(mism_bits), .snd(mism_sender)
  );

  lsm_recorder #(.SND_W(SND_W), .REC(REC_DEPTH)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .rec_en(pop_ok && !mism_flag), .rec_in(head_snd),
    .rd_idx(rec_idx), .rd_snd(rec_sender)
  );

  assign sb_drive_en   = update_mode && !sb_busy;
  assign sb_drive_word = update_mode ? head_word : '0;
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk #(
  parameter int WORD_W = 33,
  parameter int DEPTH  = 8,
  parameter int FILL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ex_di,
  input logic              sb_di,
  input logic              ex_busy,
  input logic              sb_busy,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              cmp_hit,
  input logic [FILL_W-1:0] fill,
  input logic              update_mode,
  input logic              mism_clr,
  input logic              mism_flag,
  input logic [WORD_W-1:0] mism_bits
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));
  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_busy && !pop_ok) |=> ex_busy);
  // R4
  empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_busy && !push_ok) |=> sb_busy);
  // R10
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(fill));
  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mism_flag) |-> $past(cmp_hit));
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mism_flag && !mism_clr) |=> (mism_flag && $stable(mism_bits)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism_clr |=> !mism_flag);
  // R8
  update_nocmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_mode && !mism_flag) |=> !mism_flag);
  // R1
  idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mism_flag |-> (mism_bits == '0));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_di && sb_busy) |-> !pop_ok);
  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_di && ex_busy) |-> !push_ok);
endmodule

bind lockstep_match_buf lsm_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_lsm_chk (
  .clk(clk), .rst_n(rst_n), .ex_di(ex_di), .sb_di(sb_di),
  .ex_busy(ex_busy), .sb_busy(sb_busy), .push_ok(push_ok), .pop_ok(pop_ok),
  .cmp_hit(cmp_hit), .fill(fill), .update_mode(update_mode), .mism_clr(mism_clr),
  .mism_flag(mism_flag), .mism_bits(mism_bits)
);

// File: tb/tb_lockstep_match_buf.sv
module tb_lockstep_match_buf;
  localparam int W = 33;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_di = 1'b0, sb_di = 1'b0, ex_nodata = 1'b0, update_mode = 1'b0, mism_clr = 1'b0;
  logic [W-1:0] ex_word = '0, sb_word = '0;
  logic [S-1:0] ex_sender = '0;
  logic [3:0]   rec_idx = '0;
  logic ex_busy, sb_busy, sb_drive_en, mism_flag;
  logic [W-1:0] sb_drive_word, mism_bits;
  logic [S-1:0] mism_sender, rec_sender;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lockstep_match_buf dut (
    .clk(clk), .rst_n(rst_n), .ex_di(ex_di), .ex_word(ex_word), .ex_sender(ex_sender),
    .ex_nodata(ex_nodata), .sb_di(sb_di), .sb_word(sb_word), .update_mode(update_mode),
    .mism_clr(mism_clr), .rec_idx(rec_idx), .ex_busy(ex_busy), .sb_busy(sb_busy),
    .sb_drive_en(sb_drive_en), .sb_drive_word(sb_drive_word), .mism_flag(mism_flag),
    .mism_bits(mism_bits), .mism_sender(mism_sender), .rec_sender(rec_sender)
  );

  // {nodata, executive word, standby word}
  localparam logic [2*W:0] VEC [6] = '{
    {1'b0, 33'h0_1234_5678, 33'h0_1234_5678},
    {1'b0, 33'h1_0000_0000, 33'h0_0000_0000},
    {1'b0, 33'h0_FFFF_0000, 33'h0_FFFF_00FF},
    {1'b1, 33'h0_0000_00F0, 33'h1_0000_000F},
    {1'b0, 33'h0_0000_0001, 33'h0_0000_0000},
    {1'b0, 33'h1_FFFF_FFFF, 33'h0_0000_0000}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(logic [W-1:0] w, logic [S-1:0] s, logic nd);
    ex_di = 1'b1; ex_word = w; ex_sender = s; ex_nodata = nd;
    tick();
    ex_di = 1'b0; ex_nodata = 1'b0;
  endtask

  task automatic pop(logic [W-1:0] w);
    sb_di = 1'b1; sb_word = w;
    tick();
    sb_di = 1'b0;
  endtask

  task automatic clear();
    mism_clr = 1'b1;
    tick();
    mism_clr = 1'b0;
  endtask

  function automatic logic [W-1:0] fill_word(int k);
    return {1'b1, 32'hA5A5_0000 + 32'(k)};
  endfunction

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 sb_busy", 64'(sb_busy), 64'd1);
    chk("R1 ex_busy", 64'(ex_busy), 64'd0);
    chk("R1 drive_en", 64'(sb_drive_en), 64'd0);
    chk("R1 flag", 64'(mism_flag), 64'd0);
    chk("R1 bits", 64'(mism_bits), 64'd0);
    chk("R1 sender", 64'(mism_sender), 64'd0);

    // R5 R6 table walk: compare of single transfers
    for (int i = 0; i < 6; i++) begin
      logic nd;
      logic [W-1:0] ew, sw;
      logic exp_hit;
      {nd, ew, sw} = VEC[i];
      exp_hit = (ew != sw) && !nd;
      clear();
      push(ew, S'(i + 3), nd);
      chk("R4 not empty after push", 64'(sb_busy), 64'd0);
      pop(sw);
      chk(exp_hit ? "R5 flag" : "R6 no flag", 64'(mism_flag), 64'(exp_hit));
      chk("R5 bits", 64'(mism_bits), exp_hit ? 64'(ew ^ sw) : 64'd0);
      chk("R5 sender", 64'(mism_sender), exp_hit ? 64'(i + 3) : 64'd0);
    end
    clear();

    // R3 fill to eight, then one ignored push
    for (int k = 0; k < 8; k++) begin
      push(fill_word(k), S'(10 + k), 1'b0);
      chk("R3 ex_busy during fill", 64'(ex_busy), 64'(k == 7));
    end
    push(33'h0_DEAD_BEEF, 5'd31, 1'b0);
    chk("R3 ex_busy held", 64'(ex_busy), 64'd1);

    // R8 R2 updating mode drains in order, garbage on standby bus
    update_mode = 1'b1;
    #1;
    for (int k = 0; k < 8; k++) begin
      chk("R8 drive_en", 64'(sb_drive_en), 64'd1);
      chk("R2 order", 64'(sb_drive_word), 64'(fill_word(k)));
      pop(~fill_word(k));
    end
    chk("R3 ninth push dropped, empty", 64'(sb_busy), 64'd1);
    chk("R8 drive_en off when empty", 64'(sb_drive_en), 64'd0);
    chk("R8 no compare in update", 64'(mism_flag), 64'd0);
    update_mode = 1'b0;

    // R9 history of the last pops
    rec_idx = 4'd0; #1;
    chk("R9 newest", 64'(rec_sender), 64'd17);
    rec_idx = 4'd3; #1;
    chk("R9 age3", 64'(rec_sender), 64'd14);
    rec_idx = 4'd7; #1;
    chk("R9 age7", 64'(rec_sender), 64'd10);

    // R4 pop while empty is ignored
    pop(33'h1_2222_3333);
    chk("R4 empty pop no flag", 64'(mism_flag), 64'd0);
    chk("R4 still empty", 64'(sb_busy), 64'd1);
    rec_idx = 4'd0; #1;
    chk("R4 no history on empty pop", 64'(rec_sender), 64'd17);
    push(33'h0_0000_4444, 5'd2, 1'b0);
    pop(33'h0_0000_4444);
    chk("R4 pointers intact", 64'(mism_flag), 64'd0);

    // R7 R9 freeze on first mismatch
    push(33'h0_0000_00AA, 5'd21, 1'b0);
    push(33'h0_0000_00BB, 5'd22, 1'b0);
    pop(33'h0_0000_00A9);
    chk("R5 flag", 64'(mism_flag), 64'd1);
    chk("R5 bits", 64'(mism_bits), 64'h3);
    pop(33'h1_0000_00BB);
    chk("R7 bits frozen", 64'(mism_bits), 64'h3);
    chk("R7 sender frozen", 64'(mism_sender), 64'd21);
    rec_idx = 4'd0; #1;
    chk("R9 history frozen", 64'(rec_sender), 64'd21);
    clear();
    chk("R7 cleared flag", 64'(mism_flag), 64'd0);
    chk("R7 cleared bits", 64'(mism_bits), 64'd0);

    // R7 clear wins over a same-cycle mismatch
    push(33'h0_0000_0055, 5'd6, 1'b0);
    sb_di = 1'b1; sb_word = 33'h0_0000_0054; mism_clr = 1'b1;
    tick();
    sb_di = 1'b0; mism_clr = 1'b0;
    chk("R7 clear priority", 64'(mism_flag), 64'd0);

    // R10 simultaneous push and pop
    push(33'h0_0000_1111, 5'd1, 1'b0);
    ex_di = 1'b1; ex_word = 33'h1_0000_2222; ex_sender = 5'd2;
    sb_di = 1'b1; sb_word = 33'h0_0000_1111;
    tick();
    ex_di = 1'b0; sb_di = 1'b0;
    chk("R10 one entry left", 64'(sb_busy), 64'd0);
    chk("R10 match ok", 64'(mism_flag), 64'd0);
    pop(33'h1_0000_2222);
    chk("R10 drained", 64'(sb_busy), 64'd1);
    chk("R10 second word ok", 64'(mism_flag), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule